// File: doc/BRIEF.md
# Compare Up-Counter Timer

A memory-mapped up-counting timer with three compare channels, a rollover flag and one level-sensitive interrupt line. Software reaches it through a word-addressed register port that writes on the clock edge and reads back combinationally. The count advances on ticks of a selected clock source, and a 12-bit prescaler divides those ticks. In free-run mode the counter runs to its all-ones value and wraps. In restart mode it returns to zero once it has reached the first compare value.

Each compare channel raises a status flag when the counter reaches its compare value. Software clears a flag by writing 1 to its bit. Every flag has its own interrupt enable, and the interrupt line is gated by the timer enable. A software-reset control bit returns the working registers to their initial values in a single write. The counter width is a parameter, 32 bits by default. Register reads zero-extend it.

Top module: `cmp_timer`

## Requirements
- R1: After the asynchronous reset, the control, prescaler, status, interrupt-enable and counter registers read 0. All three compare registers read all ones, and irq_o is low.
- R2: A control write (word 0) stores the data with bits 2, 4 and 10 through 15 forced to 0, so the software-reset bit (bit 15) always reads back as 0.
- R3: Control bits 8:6 select the tick source. Codes 1 and 2 select tick_main_i and code 4 selects tick_slow_i. Every other code selects no source, and the counter then holds.
- R4: The prescaler register (word 1) keeps only its low 12 bits. While enabled (control bit 0), the counter advances once for every prescaler + 1 ticks of the selected source.
- R5: In free-run mode (control bit 9 = 1), the counter steps by one per advance and wraps from all ones to 0. That wrap sets status bit 5.
- R6: An advance that brings the counter to the value of compare register k (words 4, 5, 6) sets status bit k-1 (bits 0, 1, 2). This holds in both modes.
- R7: A status write (word 2) clears each of the low six bits written as 1 and leaves the others unchanged. If a flag is set in the same cycle as its clear, the flag stays set.
- R8: The interrupt-enable register (word 3) keeps its low six bits, which use the status bit positions. irq_o is high exactly when the enable bit is 1 and some status bit and its enable bit are both 1.
- R9: In restart mode (control bit 9 = 0), an advance taken while the counter equals compare register 1 loads 0 instead of counting up.
- R10: In restart mode, a write to compare register 1 sets the counter to 0.
- R11: A control write that takes the enable bit from 0 to 1 with bit 1 set zeroes the counter. If bit 1 is clear, counting resumes from the held value. While the enable bit is 0, the counter does not change.
- R12: A control write with bit 15 set applies the written value with bits 0 to 5 also cleared. It clears the prescaler, status, interrupt-enable and counter registers and sets the compare registers to all ones.
- R13: Words 7 and 8 and any word above 9 read 0. Word 9 returns the counter, and writes to word 9 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| tick_main_i | input | 1 | Main clock-source tick enable |
| tick_slow_i | input | 1 | Slow clock-source tick enable |
| irq_o | output | 1 | Level interrupt |

## Verification
The rollover flag is the hardest case to reach from the ports, because the counter cannot be loaded and must pass through every value before it wraps. The bench therefore builds the timer with a 10-bit counter and runs it with a prescaler of 0 and a steady main tick, so several wraps fit in one run. A flag being set in the same cycle as its clear is the other case that is hard to hit. To cover it, the bench keeps writing clears to the status register while the counter sweeps through the compare values, and a cycle-accurate model judges every one of those cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned AW    = 4;
  localparam int unsigned N_CMP = 3;
  localparam int unsigned ST_W  = 6;
  localparam int unsigned ST_ROLL = 5;

  localparam logic [AW-1:0] A_CTRL = 4'd0;
  localparam logic [AW-1:0] A_PRE  = 4'd1;
  localparam logic [AW-1:0] A_STAT = 4'd2;
  localparam logic [AW-1:0] A_IEN  = 4'd3;
  localparam logic [AW-1:0] A_CMP1 = 4'd4;
  localparam logic [AW-1:0] A_CNT  = 4'd9;

  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_ENMOD = 1;
  localparam int unsigned B_SRC   = 6;
  localparam int unsigned B_FRR   = 9;
  localparam int unsigned B_SWR   = 15;

  // bits never stored on a control write (includes the reset trigger)
  localparam logic [REG_W-1:0] CTRL_DROP = 32'h0000_FC14;
  // extra bits cleared by a software reset
  localparam logic [REG_W-1:0] CTRL_SOFT = 32'h0000_003F;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PRE_W = 12
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [AW-1:0]                addr_i,
  input  logic [REG_W-1:0]             wdata_i,
  output logic [REG_W-1:0]             ctrl_o,
  output logic [PRE_W-1:0]             pre_o,
  output logic [ST_W-1:0]              ien_o,
  output logic [N_CMP-1:0][CNT_W-1:0]  cmp_o,
  output logic                         soft_rst_o,
  output logic                         zero_req_o,
  output logic [ST_W-1:0]              st_clr_o
);
  logic [REG_W-1:0] ctrl_q;
  logic [PRE_W-1:0] pre_q;
  logic [ST_W-1:0]  ien_q;
  logic             wr_ctrl, en_rise, cmp1_restart;

  assign wr_ctrl      = we_i && (addr_i == A_CTRL);
  assign soft_rst_o   = wr_ctrl && wdata_i[B_SWR];
  assign en_rise      = wr_ctrl && !wdata_i[B_SWR] && !ctrl_q[B_EN]
                        && wdata_i[B_EN] && wdata_i[B_ENMOD];
  assign cmp1_restart = we_i && (addr_i == A_CMP1) && !ctrl_q[B_FRR];
  assign zero_req_o   = en_rise || cmp1_restart;
  assign st_clr_o     = (we_i && addr_i == A_STAT) ? wdata_i[ST_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      ien_q  <= '0;
    end else if (soft_rst_o) begin
      ctrl_q <= wdata_i & ~(CTRL_DROP | CTRL_SOFT);
      pre_q  <= '0;
      ien_q  <= '0;
    end else if (we_i) begin
      if (addr_i == A_CTRL) ctrl_q <= wdata_i & ~CTRL_DROP;
      if (addr_i == A_PRE)  pre_q  <= wdata_i[PRE_W-1:0];
      if (addr_i == A_IEN)  ien_q  <= wdata_i[ST_W-1:0];
    end
  end

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    logic [CNT_W-1:0] cmp_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       cmp_q <= '1;
      else if (soft_rst_o)                               cmp_q <= '1;
      else if (we_i && addr_i == A_CMP1 + AW'(k))        cmp_q <= wdata_i[CNT_W-1:0];
    end
    assign cmp_o[k] = cmp_q;
  end

  assign ctrl_o = ctrl_q;
  assign pre_o  = pre_q;
  assign ien_o  = ien_q;
endmodule

// File: rtl/tmr_tick.sv
module tmr_tick #(
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [2:0]       src_i,
  input  logic             tick_main_i,
  input  logic             tick_slow_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic             clr_i,
  output logic             adv_o
);
  logic             src_tick;
  logic [PRE_W-1:0] div_q;

  always_comb begin
    unique case (src_i)
      3'd1, 3'd2: src_tick = tick_main_i;
      3'd4:       src_tick = tick_slow_i;
      default:    src_tick = 1'b0;
    endcase
  end

  // >= covers a prescaler lowered below the running divider count
  assign adv_o = en_i && src_tick && (div_q >= pre_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 div_q <= '0;
    else if (clr_i)              div_q <= '0;
    else if (en_i && src_tick)   div_q <= adv_o ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        adv_i,
  input  logic                        frr_i,
  input  logic [N_CMP-1:0][CNT_W-1:0] cmp_i,
  input  logic                        soft_rst_i,
  input  logic                        zero_req_i,
  input  logic [ST_W-1:0]             st_clr_i,
  output logic [CNT_W-1:0]            cnt_o,
  output logic [ST_W-1:0]             st_o
);
  logic [CNT_W-1:0] cnt_q, nxt;
  logic [ST_W-1:0]  st_q, set;
  logic             hit;

  assign hit = !frr_i && (cnt_q == cmp_i[0]);
  assign nxt = hit ? '0 : cnt_q + 1'b1;

  always_comb begin
    set = '0;
    set[ST_ROLL] = adv_i && !hit && (cnt_q == '1);
    for (int k = 0; k < N_CMP; k++) set[k] = adv_i && (nxt == cmp_i[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      st_q  <= '0;
    end else if (soft_rst_i) begin
      cnt_q <= '0;
      st_q  <= '0;
    end else begin
      if (zero_req_i) cnt_q <= '0;
      else if (adv_i) cnt_q <= nxt;
      st_q <= (st_q & ~st_clr_i) | set;  // set wins over clear
    end
  end

  assign cnt_o = cnt_q;
  assign st_o  = st_q;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PRE_W = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic [3:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  input  logic        tick_main_i,
  input  logic        tick_slow_i,
  output logic        irq_o
);
  logic [REG_W-1:0]            ctrl;
  logic [PRE_W-1:0]            pre;
  logic [ST_W-1:0]             ien, stat, st_clr;
  logic [N_CMP-1:0][CNT_W-1:0] cmp;
  logic [CNT_W-1:0]            cnt;
  logic                        soft_rst, zero_req, adv;

  tmr_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) i_regs (
    .clk_i, .rst_ni, .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .ctrl_o(ctrl), .pre_o(pre), .ien_o(ien), .cmp_o(cmp),
    .soft_rst_o(soft_rst), .zero_req_o(zero_req), .st_clr_o(st_clr)
  );

  tmr_tick #(.PRE_W(PRE_W)) i_tick (
    .clk_i, .rst_ni, .en_i(ctrl[B_EN]), .src_i(ctrl[B_SRC+:3]),
    .tick_main_i, .tick_slow_i, .pre_i(pre), .clr_i(soft_rst || zero_req),
    .adv_o(adv)
  );

  tmr_core #(.CNT_W(CNT_W)) i_core (
    .clk_i, .rst_ni, .adv_i(adv), .frr_i(ctrl[B_FRR]), .cmp_i(cmp),
    .soft_rst_i(soft_rst), .zero_req_i(zero_req), .st_clr_i(st_clr),
    .cnt_o(cnt), .st_o(stat)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_CTRL:  bus_rdata_o = ctrl;
      A_PRE:   bus_rdata_o = REG_W'(pre);
      A_STAT:  bus_rdata_o = REG_W'(stat);
      A_IEN:   bus_rdata_o = REG_W'(ien);
      A_CNT:   bus_rdata_o = REG_W'(cnt);
      default: bus_rdata_o = '0;
    endcase
    for (int k = 0; k < N_CMP; k++)
      if (bus_addr_i == A_CMP1 + AW'(k)) bus_rdata_o = REG_W'(cmp[k]);
  end

  assign irq_o = ctrl[B_EN] && |(stat & ien);
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [3:0]       addr_i,
  input logic [31:0]      wdata_i,
  input logic [31:0]      ctrl_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [5:0]       st_i,
  input logic [CNT_W-1:0] cmp1_i,
  input logic             adv_i,
  input logic             zero_i,
  input logic             soft_i,
  input logic             irq_i
);
  a_r2_ctrl_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i & 32'h0000_FC14) == 32'h0);

  a_r8_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> ctrl_i[0]);

  a_r11_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[0] && !we_i) |=> $stable(cnt_i));

  a_r12_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 4'd0 && wdata_i[15])
    |=> (cnt_i == '0 && st_i == '0 && cmp1_i == '1 && ctrl_i[5:0] == '0));

  a_r5_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && ctrl_i[9] && !zero_i && !soft_i) |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1));

  a_r13_cnt_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 4'd9 && !adv_i) |=> $stable(cnt_i));
endmodule

bind cmp_timer tmr_chk #(.CNT_W(CNT_W)) i_tmr_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bus_we_i), .addr_i(bus_addr_i),
  .wdata_i(bus_wdata_i), .ctrl_i(ctrl), .cnt_i(cnt), .st_i(stat),
  .cmp1_i(cmp[0]), .adv_i(adv), .zero_i(zero_req), .soft_i(soft_rst), .irq_i(irq_o)
);

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
  localparam int CW = 10;
  localparam logic [CW-1:0] MAXV = '1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [3:0]  bus_addr_i = 4'd0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        tick_main_i = 1'b0;
  logic        tick_slow_i = 1'b0;
  logic        irq_o;

  cmp_timer #(.CNT_W(CW)) i_cmp_timer (.*);

  always #2.5 clk_i = ~clk_i;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  bit    done = 0;
  string phase = "R1 reset values";

  // reference state
  logic [31:0]   m_ctrl;
  logic [11:0]   m_pre, m_pc;
  logic [5:0]    m_sr, m_ier;
  logic [CW-1:0] m_cmp [3];
  logic [CW-1:0] m_cnt;

  task automatic m_reset();
    m_ctrl = 0; m_pre = 0; m_pc = 0; m_sr = 0; m_ier = 0; m_cnt = 0;
    for (int k = 0; k < 3; k++) m_cmp[k] = MAXV;
  endtask

  task automatic m_step();
    int src; bit tk, adv, wrap0; logic [5:0] setb, nsr; logic [CW-1:0] nx;
    src = int'(m_ctrl[8:6]);
    tk = (src == 1 || src == 2) ? tick_main_i : (src == 4) ? tick_slow_i : 1'b0;
    adv = 0;
    if (m_ctrl[0] && tk) begin
      if (m_pc >= m_pre) begin adv = 1; m_pc = 0; end else m_pc = m_pc + 1;
    end
    setb = 0;
    if (adv) begin
      wrap0 = !m_ctrl[9] && m_cnt == m_cmp[0];
      nx = wrap0 ? '0 : m_cnt + 1;
      if (!wrap0 && m_cnt == MAXV) setb[5] = 1;
      for (int k = 0; k < 3; k++) if (nx == m_cmp[k]) setb[k] = 1;
      m_cnt = nx;
    end
    nsr = m_sr | setb;
    if (bus_we_i) begin
      case (bus_addr_i)
        4'd0: if (bus_wdata_i[15]) begin
                m_ctrl = bus_wdata_i & ~32'h0000_FC3F; m_pre = 0; m_ier = 0;
                nsr = 0; m_cnt = 0; m_pc = 0;
                for (int k = 0; k < 3; k++) m_cmp[k] = MAXV;
              end else begin
                if (!m_ctrl[0] && bus_wdata_i[0] && bus_wdata_i[1]) begin m_cnt = 0; m_pc = 0; end
                m_ctrl = bus_wdata_i & ~32'h0000_FC14;
              end
        4'd1: m_pre = bus_wdata_i[11:0];
        4'd2: nsr = (m_sr & ~bus_wdata_i[5:0]) | setb;
        4'd3: m_ier = bus_wdata_i[5:0];
        4'd4, 4'd5, 4'd6: begin
                m_cmp[bus_addr_i - 4] = bus_wdata_i[CW-1:0];
                if (bus_addr_i == 4 && !m_ctrl[9]) begin m_cnt = 0; m_pc = 0; end
              end
        default: ;
      endcase
    end
    m_sr = nsr;
  endtask

  function automatic logic [31:0] m_read(logic [3:0] a);
    case (a)
      4'd0: return m_ctrl;
      4'd1: return 32'(m_pre);
      4'd2: return 32'(m_sr);
      4'd3: return 32'(m_ier);
      4'd4, 4'd5, 4'd6: return 32'(m_cmp[a - 4]);
      4'd9: return 32'(m_cnt);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) m_reset(); else m_step();
    #1;
    begin
      logic [31:0] er; logic ei;
      er = m_read(bus_addr_i);
      ei = m_ctrl[0] && |(m_sr & m_ier);
      n_cmp++;
      if (bus_rdata_o !== er || irq_o !== ei) begin
        n_bad++;
        $display("FAIL %s addr=%0d rdata=%h exp=%h irq=%b exp=%b",
                 phase, bus_addr_i, bus_rdata_o, er, irq_o, ei);
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 30000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i); bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i); bus_we_i = 0;
  endtask

  task automatic idle(input int n, input logic [3:0] a);
    bus_addr_i = a;
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    phase = "R1 reset values";
    for (int a = 0; a < 11; a++) idle(1, 4'(a));

    phase = "R13 map and read-only counter";
    wr(4'd9, 32'h155); wr(4'd7, 32'hFFFF_FFFF);
    idle(1, 4'd7); idle(1, 4'd8); idle(1, 4'd9); idle(1, 4'd12); idle(1, 4'd15);

    phase = "R2 control mask";
    wr(4'd0, 32'h7FFF_7FFE); idle(2, 4'd0);
    phase = "R4 prescaler mask";
    wr(4'd1, 32'hFFFF_FFFF); idle(1, 4'd1);
    wr(4'd1, 32'h0); wr(4'd0, 32'h0);

    tick_main_i = 1;
    phase = "R3 code 0 selects nothing";
    wr(4'd0, 32'h0000_0001); idle(6, 4'd9);
    phase = "R3 code 3 selects nothing";
    wr(4'd0, 32'h0000_00C1); idle(6, 4'd9);
    phase = "R3 code 4 slow tick";
    wr(4'd0, 32'h0000_0101); bus_addr_i = 4'd9;
    for (int i = 0; i < 16; i++) begin @(negedge clk_i); tick_slow_i = (i % 3 == 0); end
    tick_slow_i = 0;
    phase = "R3 code 2 main tick";
    wr(4'd0, 32'h0000_0081); idle(8, 4'd9);

    phase = "R4 divide by three";
    wr(4'd1, 32'd2); idle(15, 4'd9);
    phase = "R4 divide with sparse ticks";
    for (int i = 0; i < 20; i++) begin @(negedge clk_i); tick_main_i = (i % 4 != 1); end
    tick_main_i = 1;
    phase = "R4 prescaler lowered mid-count";
    wr(4'd1, 32'd5); idle(3, 4'd9); wr(4'd1, 32'd1); idle(8, 4'd9); wr(4'd1, 32'd0);

    phase = "R11 frozen while disabled";
    wr(4'd0, 32'h0000_0040); idle(6, 4'd9);
    phase = "R11 resume without zeroing";
    wr(4'd0, 32'h0000_0041); idle(6, 4'd9);
    phase = "R11 enable-mode zeroes";
    wr(4'd0, 32'h0000_0040); wr(4'd0, 32'h0000_0043); idle(6, 4'd9);

    phase = "R6 compare flags free-run";
    wr(4'd0, 32'h0000_0241); wr(4'd5, 32'd40); wr(4'd6, 32'd60); wr(4'd4, 32'd90);
    wr(4'd3, 32'h0000_0006); idle(120, 4'd2);
    phase = "R7 clear one flag";
    wr(4'd2, 32'h0000_0002); idle(2, 4'd2);
    wr(4'd2, 32'h0); idle(2, 4'd2);
    phase = "R8 enable mask and gating";
    wr(4'd3, 32'hFFFF_FFFF); idle(1, 4'd3);
    wr(4'd0, 32'h0000_0240); idle(3, 4'd2);
    wr(4'd0, 32'h0000_0241); idle(3, 4'd2);

    phase = "R5 rollover";
    wr(4'd2, 32'h3F); wr(4'd3, 32'h20); idle(1100, 4'd2);
    phase = "R7 set and clear coinciding";
    wr(4'd3, 32'h27);
    for (int i = 0; i < 600; i++) begin wr(4'd2, 32'h3F); idle(1, 4'd2); end

    phase = "R9 restart on compare 1";
    wr(4'd0, 32'h0000_0041); wr(4'd2, 32'h3F); wr(4'd5, 32'd12);
    wr(4'd4, 32'd20); idle(50, 4'd9); idle(30, 4'd2);
    phase = "R10 compare 1 write zeroes";
    idle(7, 4'd9); wr(4'd4, 32'd30); idle(40, 4'd9);

    phase = "R12 soft reset";
    wr(4'd3, 32'h3F); wr(4'd1, 32'd3);
    wr(4'd0, 32'hE000_8243);
    for (int a = 0; a < 10; a++) idle(1, 4'(a));
    idle(5, 4'd9);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule